// File: doc/BRIEF.md
# Move-Only Processor Core with Address-Selected Functions

This block is a minimal processor that runs a single kind of instruction: copy the word held at a source cell into a destination cell. Each instruction is two memory words, the source address followed by the destination address. There is no opcode. The destination address alone decides what the copy does.

Most destinations are plain storage. A few high cells each carry a fixed arithmetic function that merges the incoming word with the word the cell already holds. Two further cells are control ports. Writing the first one redirects the instruction pointer. Writing the second one redirects it only when the XOR cell currently holds zero.

Program and data share one word-addressed memory. While the core is idle or halted, that memory is filled through a simple load port. A start pulse then runs the program from address 0 until it reaches a move whose source address is all ones.

Top module: `tt_move_core`

## Requirements
- R1: After reset, `done_o` is 0, `wr_valid_o` is 0 and `ip_o` is 0.
- R2: A `load_en` write takes effect only while the core is idle or halted. Load writes presented while a program runs are ignored.
- R3: Each move reads its source address from the cell at IP and its destination address from the cell at IP+1. Only the low 8 bits of each word are used. A move takes exactly 5 clock cycles. After a move that is not a jump, IP advances by 2, modulo 256. A start pulse sets IP to 0.
- R4: A destination outside 0xF0–0xF3 and 0xF8–0xF9 receives the source word unchanged.
- R5: Destination 0xF0 becomes its old value plus the source word, modulo 2^16.
- R6: Destination 0xF1 becomes its old value minus the source word, modulo 2^16.
- R7: Destination 0xF2 becomes its old value AND the source word. Destination 0xF3 becomes its old value XOR the source word.
- R8: A move to 0xF8 loads IP with the low 8 bits of the source word. It writes no memory cell and raises no `wr_valid_o`.
- R9: A move to 0xF9 loads IP from the source word when cell 0xF3 holds zero. Otherwise IP advances by 2. It writes no memory cell.
- R10: A source address of 0xFF halts the core. `done_o` rises two cycles after the move begins, IP stays on the halting move, and no memory write occurs. `done_o` then holds until the next start.
- R11: Each memory-writing move raises `wr_valid_o` for exactly one cycle, starting the cycle after the write. During that cycle `wr_addr_o` and `wr_data_o` show the destination address and the new value.
- R12: A value written by one move is the value read by the following move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Memory load strobe, honoured only when idle or halted |
| load_addr | input | 8 | Load address |
| load_data | input | 16 | Load data |
| start | input | 1 | Begin execution at address 0 |
| done_o | output | 1 | Core has halted |
| ip_o | output | 8 | Instruction pointer |
| wr_valid_o | output | 1 | One-cycle pulse after each memory write by a move |
| wr_addr_o | output | 8 | Destination of the reported write |
| wr_data_o | output | 16 | Value written |

## Verification
A corrupted instruction pointer or a wrong phase counter appears on `ip_o` at the end of the affected move, which is at most five cycles later. It also shifts the timing of every later write pulse.

A wrong function selection or a stale operand appears on `wr_data_o` one cycle after the faulty write. A corrupted zero flag appears only later, as a wrong branch taken at the next conditional port move. A load that is wrongly accepted during a run is caught the same way, once the altered cell steers control flow.

// File: rtl/tt_pkg.sv
package tt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FSRC,
    ST_FDST,
    ST_RDA,
    ST_RDB,
    ST_EXEC,
    ST_HALT
  } state_t;

  typedef enum logic [2:0] {
    FN_STORE,
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_XOR,
    FN_JMP,
    FN_JZ
  } fn_t;

endpackage

// File: rtl/tt_ram.sv
module tt_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // one write port, one registered read port: block RAM shape
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tt_dst_decode.sv
module tt_dst_decode
  import tt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] dst,
  output fn_t           fn
);
  localparam logic [AW-1:0] BASE   = AW'((1 << AW) - 16);
  localparam logic [AW-1:0] A_ADD  = BASE;
  localparam logic [AW-1:0] A_SUB  = BASE + AW'(1);
  localparam logic [AW-1:0] A_AND  = BASE + AW'(2);
  localparam logic [AW-1:0] A_XOR  = BASE + AW'(3);
  localparam logic [AW-1:0] A_JMP  = BASE + AW'(8);
  localparam logic [AW-1:0] A_JZ   = BASE + AW'(9);

  always_comb begin
    unique case (dst)
      A_ADD:   fn = FN_ADD;
      A_SUB:   fn = FN_SUB;
      A_AND:   fn = FN_AND;
      A_XOR:   fn = FN_XOR;
      A_JMP:   fn = FN_JMP;
      A_JZ:    fn = FN_JZ;
      default: fn = FN_STORE;
    endcase
  end
endmodule

// File: rtl/tt_alu.sv
module tt_alu
  import tt_pkg::*;
#(
  parameter int DW = 16
) (
  input  fn_t           fn,
  input  logic [DW-1:0] incoming,
  input  logic [DW-1:0] current,
  output logic [DW-1:0] result
);
  always_comb begin
    unique case (fn)
      FN_ADD:  result = current + incoming;
      FN_SUB:  result = current - incoming;
      FN_AND:  result = current & incoming;
      FN_XOR:  result = current ^ incoming;
      default: result = incoming;
    endcase
  end
endmodule

// File: rtl/tt_move_core.sv
module tt_move_core
  import tt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          start,
  output logic          done_o,
  output logic [AW-1:0] ip_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam logic [AW-1:0] HALT_SRC = {AW{1'b1}};
  localparam logic [AW-1:0] ZERO_CELL = AW'((1 << AW) - 13);
  localparam logic [AW-1:0] IP_STEP = AW'(2);

  state_t        state;
  logic [AW-1:0] ip;
  logic [AW-1:0] src_q;
  logic [AW-1:0] dst_q;
  logic [DW-1:0] opa_q;
  logic          zf;

  fn_t           fn;
  logic [DW-1:0] alu_res;
  logic [DW-1:0] rdata;
  logic [AW-1:0] raddr;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [DW-1:0] ram_wdata;
  logic          is_rest;
  logic          is_ctrl;

  tt_dst_decode #(.AW(AW)) u_dec (.dst(dst_q), .fn(fn));

  tt_alu #(.DW(DW)) u_alu (
    .fn(fn), .incoming(opa_q), .current(rdata), .result(alu_res)
  );

  tt_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(raddr), .rdata(rdata)
  );

  assign is_rest = (state == ST_IDLE) || (state == ST_HALT);
  assign is_ctrl = (fn == FN_JMP) || (fn == FN_JZ);

  // write port: loader while resting, write-back in the last phase
  always_comb begin
    if (is_rest) begin
      ram_we    = load_en;
      ram_waddr = load_addr;
      ram_wdata = load_data;
    end else begin
      ram_we    = (state == ST_EXEC) && !is_ctrl;
      ram_waddr = dst_q;
      ram_wdata = alu_res;
    end
  end

  // read address per phase; data returns one cycle later
  always_comb begin
    unique case (state)
      ST_FSRC: raddr = ip;
      ST_FDST: raddr = ip + AW'(1);
      ST_RDA:  raddr = src_q;
      ST_RDB:  raddr = dst_q;
      default: raddr = ip;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ip         <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      opa_q      <= '0;
      zf         <= 1'b1;
      done_o     <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (ram_we && ram_waddr == ZERO_CELL) zf <= (ram_wdata == '0);
      unique case (state)
        ST_IDLE, ST_HALT: begin
          if (start) begin
            state  <= ST_FSRC;
            ip     <= '0;
            done_o <= 1'b0;
          end
        end
        ST_FSRC: state <= ST_FDST;
        ST_FDST: begin
          src_q <= rdata[AW-1:0];
          if (rdata[AW-1:0] == HALT_SRC) begin
            state  <= ST_HALT;
            done_o <= 1'b1;
          end else begin
            state <= ST_RDA;
          end
        end
        ST_RDA: begin
          dst_q <= rdata[AW-1:0];
          state <= ST_RDB;
        end
        ST_RDB: begin
          opa_q <= rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_FSRC;
          if (fn == FN_JMP) begin
            ip <= opa_q[AW-1:0];
          end else if (fn == FN_JZ) begin
            ip <= zf ? opa_q[AW-1:0] : ip + IP_STEP;
          end else begin
            ip         <= ip + IP_STEP;
            wr_valid_o <= 1'b1;
            wr_addr_o  <= dst_q;
            wr_data_o  <= alu_res;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ip_o = ip;

  // R2: the loader never reaches memory in a fetch or operand phase
  assert_no_load_run_R2: assert property (@(posedge clk) disable iff (rst)
    (!is_rest && state != ST_EXEC) |-> !ram_we);

  // R3: a non-jump move steps the pointer by two
  assert_ip_step_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && !is_ctrl) |=> (ip == $past(ip) + IP_STEP));

  // R8: control ports never report a memory write
  assert_ctrl_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && is_ctrl) |=> !wr_valid_o);

  // R9: untaken conditional jump falls through
  assert_jz_fall_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && fn == FN_JZ && !zf) |=> (ip == $past(ip) + IP_STEP));

  // R10: halted state holds until a new start
  assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start) |=> done_o);

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> !wr_valid_o);

  // R11: a write report lasts a single cycle
  assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |=> !wr_valid_o);

endmodule

// File: tb/tt_move_core_tb_top.sv
module tt_move_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic        start = 1'b0;
  logic        done_o;
  logic [7:0]  ip_o;
  logic        wr_valid_o;
  logic [7:0]  wr_addr_o;
  logic [15:0] wr_data_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tt_move_core dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .start(start), .done_o(done_o), .ip_o(ip_o),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  // ---------------- behavioural reference ----------------
  logic [15:0] mmem [256];
  logic [7:0]  m_ip = '0;
  logic        m_done = 1'b0;
  logic        m_run = 1'b0;
  int          m_ph = 0;
  logic        m_wv = 1'b0;
  logic [7:0]  m_wa = '0;
  logic [15:0] m_wd = '0;
  logic        live = 1'b0;

  always @(posedge clk) begin
    logic [7:0]  a, b;
    logic [15:0] va, vb, nv;
    m_wv = 1'b0;
    if (rst) begin
      m_run = 1'b0; m_ph = 0; m_ip = '0; m_done = 1'b0;
    end else if (!m_run) begin
      if (load_en) mmem[load_addr] = load_data;
      if (start) begin m_run = 1'b1; m_ph = 1; m_ip = '0; m_done = 1'b0; end
    end else if (m_ph == 2) begin
      if (mmem[m_ip][7:0] == 8'hFF) begin m_run = 1'b0; m_done = 1'b1; end
      else m_ph = 3;
    end else if (m_ph == 5) begin
      a  = mmem[m_ip][7:0];
      b  = mmem[8'(m_ip + 8'd1)][7:0];
      va = mmem[a];
      vb = mmem[b];
      m_ph = 1;
      if (b == 8'hF8) m_ip = va[7:0];
      else if (b == 8'hF9) m_ip = (mmem[8'hF3] == 16'h0) ? va[7:0] : 8'(m_ip + 8'd2);
      else begin
        case (b)
          8'hF0:   nv = vb + va;
          8'hF1:   nv = vb - va;
          8'hF2:   nv = vb & va;
          8'hF3:   nv = vb ^ va;
          default: nv = va;
        endcase
        mmem[b] = nv;
        m_wv = 1'b1; m_wa = b; m_wd = nv;
        m_ip = 8'(m_ip + 8'd2);
      end
    end else begin
      m_ph = m_ph + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [23:0] obs [$];

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk(ip_o == m_ip, "R3", "ip", ip_o, m_ip);
      chk(done_o == m_done, "R10", "done", done_o, m_done);
      chk(wr_valid_o == m_wv, "R11", "wr_valid", wr_valid_o, m_wv);
      if (m_wv && wr_valid_o)
        chk({wr_addr_o, wr_data_o} == {m_wa, m_wd}, "R4", "write",
            {wr_addr_o, wr_data_o}, {m_wa, m_wd});
    end
    if (wr_valid_o) obs.push_back({wr_addr_o, wr_data_o});
  end

  logic [15:0] img [256];

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
  endtask

  task automatic load_img();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = 8'(i); load_data = img[i];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run_prog(input bit inject, output int cyc);
    obs.delete();
    @(negedge clk);
    start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (inject && cyc == 2) begin
        load_en = 1'b1; load_addr = 8'h83; load_data = 16'h0000;
      end
      if (inject && cyc == 3) load_en = 1'b0;
    end while (!done_o && cyc < 500);
  endtask

  task automatic chk_obs(input int idx, input logic [23:0] exp, input string req);
    if (idx < obs.size()) chk(obs[idx] == exp, req, "write stream", obs[idx], exp);
    else chk(1'b0, req, "missing write", 0, exp);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;
    // R1 reset state
    chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    chk(wr_valid_o == 1'b0, "R1", "wr_valid after reset", wr_valid_o, 0);
    chk(ip_o == 8'h00, "R1", "ip after reset", ip_o, 0);

    // Program 1: function cells, wrap on add, back-to-back dependency
    clear_img();
    img[0] = 16'h80; img[1] = 16'hF0; img[2] = 16'h82; img[3] = 16'hF0;
    img[4] = 16'h81; img[5] = 16'hF1; img[6] = 16'h80; img[7] = 16'hF2;
    img[8] = 16'h81; img[9] = 16'hF3; img[10] = 16'hF0; img[11] = 16'h40;
    img[12] = 16'hFF;
    img[8'h80] = 16'h1234; img[8'h81] = 16'h0F0F; img[8'h82] = 16'hFFFF;
    img[8'hF0] = 16'h0001; img[8'hF1] = 16'h0010; img[8'hF2] = 16'hFF00;
    img[8'hF3] = 16'h00FF;
    load_img();
    run_prog(1'b0, cyc);
    chk(cyc == 33, "R3", "cycles to halt prog1", cyc, 33);
    chk(obs.size() == 6, "R11", "write count prog1", obs.size(), 6);
    chk_obs(0, 24'hF0_1235, "R5");
    chk_obs(1, 24'hF0_1234, "R5");
    chk_obs(2, 24'hF1_F101, "R6");
    chk_obs(3, 24'hF2_1200, "R7");
    chk_obs(4, 24'hF3_0FF0, "R7");
    chk_obs(5, 24'h40_1234, "R12");
    chk(ip_o == 8'h0C, "R10", "ip on halt", ip_o, 8'h0C);
    repeat (6) @(negedge clk);
    chk(done_o == 1'b1, "R10", "done held", done_o, 1);

    // Program 2: conditional port both ways, unconditional port
    clear_img();
    img[0] = 16'h90; img[1] = 16'hF9; img[2] = 16'h93; img[3] = 16'hF3;
    img[4] = 16'h91; img[5] = 16'hF9;
    img[8'h20] = 16'h90; img[8'h21] = 16'hF8;
    img[8'h10] = 16'h92; img[8'h11] = 16'h50; img[8'h12] = 16'hFF;
    img[8'h90] = 16'h0010; img[8'h91] = 16'h0020; img[8'h93] = 16'h0005;
    img[8'hF3] = 16'h0005;
    load_img();
    run_prog(1'b0, cyc);
    chk(cyc == 28, "R9", "cycles to halt prog2", cyc, 28);
    chk(obs.size() == 2, "R8", "write count prog2", obs.size(), 2);
    chk_obs(0, 24'hF3_0000, "R7");
    chk_obs(1, 24'h50_0000, "R8");
    chk(ip_o == 8'h12, "R8", "ip after jumps", ip_o, 8'h12);

    // Program 3: pointer wrap, load attempt during run is ignored
    clear_img();
    img[0] = 16'h82; img[1] = 16'hF9; img[2] = 16'hFF;
    img[8'hFE] = 16'h83; img[8'hFF] = 16'hF3;
    img[8'h82] = 16'h00FE; img[8'h83] = 16'h0001;
    load_img();
    run_prog(1'b1, cyc);
    chk(cyc == 18, "R2", "cycles to halt prog3", cyc, 18);
    chk(obs.size() == 1, "R2", "write count prog3", obs.size(), 1);
    chk_obs(0, 24'hF3_0001, "R2");
    chk(ip_o == 8'h02, "R3", "ip after wrap", ip_o, 8'h02);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule